// File: doc/BRIEF.md
# Periodic Wake-up Timer

This block raises an interrupt flag at a fixed, programmable interval. The interval is set by a 16-bit rate value and lasts 2 × (rate + 1) periods of a selected time base. That base is either the bus clock or a slow free-running clock. The slow clock arrives asynchronously, so it is brought into the bus domain before its rising edges are counted. Software reaches the block through a small byte-wide register port. The port has two rate bytes and one control/status byte, which holds the run bit, the time-base select, the interrupt enable and the sticky timeout flag.

The rate bytes can be changed only while the timer is stopped. While it runs, writes to them are dropped. Stopping the timer clears its count, and starting it again begins a new interval from zero. At every timeout the count reloads, so later intervals keep a fixed spacing whether or not software has cleared the flag. When the slow clock is the base, the first interval after start is longer by two to three slow-clock periods. This comes from the synchronizer and from the gate-release edges that are discarded after start.

Top module: `wake_tick_timer`

## Requirements
- R1: After reset, both rate bytes read 0x00, the control byte reads 0x00 and `irq` is low.
- R2: Rate bits 15:8 are read and written at address 0 and rate bits 7:0 at address 1. Both can be read at any time.
- R3: While the run bit is set, writes to address 0 or 1 leave the stored rate unchanged.
- R4: With the bus clock selected, the flag first sets 2 × (rate + 1) bus cycles after the clock edge that wrote the run bit, and it sets again every 2 × (rate + 1) cycles after that. This holds up to rate 0xFFFF.
- R5: With the slow clock selected, the flag sets every 2 × (rate + 1) slow-clock rising edges. The first timeout after start comes 2 to 3 slow-clock periods later than that interval.
- R6: Clearing the run bit stops counting and zeroes the count. Setting it again starts a full new interval.
- R7: The flag is sticky and is set only by a timeout. Writing 1 to control bit 7 clears it and writing 0 leaves it alone. A timeout in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly when the flag and the interrupt-enable bit are both set.
- R9: Control byte at address 2: bit 0 is run, bit 1 selects the time base (0 = slow clock, 1 = bus clock), bit 2 is interrupt enable and bit 7 is the flag. Bits 6:3 read 0, and address 3 reads 0x00 and ignores writes.
- R10: A timeout that occurs while the flag is already set is not counted. The count still reloads, so the spacing of later timeouts does not drift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Slow time-base clock, asynchronous to `clk` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures intervals in exact bus cycles, including at rate 0 and at rate 0xFFFF. An off-by-one in the terminal count therefore shows up as an interval one or two cycles off, and a counter that is too narrow never reaches its timeout. It places a clearing write in the same cycle as a timeout, which catches a design that lets the clear win and loses an event. It also leaves the flag set across several timeouts and then checks the spacing, which catches a counter that stalls or restarts while the flag is pending. In slow-clock mode it checks both the exact steady interval and the window for the first interval, so a missing or over-long gate release is reported.

// File: rtl/wtt_pkg.sv
package wtt_pkg;

    localparam int DATA_W      = 8;
    localparam int RATE_W      = 16;
    localparam int RATE_BYTES  = RATE_W / DATA_W;
    localparam int CNT_W       = RATE_W + 1;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;
    localparam int GATE_EDGES  = 3;
    localparam int GATE_W      = $clog2(GATE_EDGES + 1);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(RATE_BYTES);

    localparam int BIT_RUN  = 0;
    localparam int BIT_SRC  = 1;
    localparam int BIT_IE   = 2;
    localparam int BIT_FLAG = 7;

    typedef enum logic {
        SRC_SLOW = 1'b0,
        SRC_BUS  = 1'b1
    } src_e;

    typedef struct packed {
        logic flag;
        logic irq_en;
        src_e src;
        logic run;
    } ctl_t;

    function automatic logic [DATA_W-1:0] ctl_to_byte(ctl_t c);
        logic [DATA_W-1:0] b;
        b           = '0;
        b[BIT_RUN]  = c.run;
        b[BIT_SRC]  = logic'(c.src);
        b[BIT_IE]   = c.irq_en;
        b[BIT_FLAG] = c.flag;
        return b;
    endfunction

    // Last count value of an interval; the interval spans 2*(rate+1) ticks.
    function automatic logic [CNT_W-1:0] terminal_count(logic [RATE_W-1:0] r);
        return {r, 1'b1};
    endfunction

endpackage

// File: rtl/wtt_regs.sv
module wtt_regs
    import wtt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              timeout,
    output logic [DATA_W-1:0] rdata,
    output logic [RATE_W-1:0] rate,
    output ctl_t              ctl
);

    logic wr_ctl;
    assign wr_ctl = wr && (addr == ADDR_CTRL);

    // Rate bytes: the most significant byte sits at the lowest address.
    for (genvar gb = 0; gb < RATE_BYTES; gb++) begin : g_byte
        localparam logic [ADDR_W-1:0] BADDR = ADDR_W'(RATE_BYTES - 1 - gb);
        logic [DATA_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr && (addr == BADDR) && !ctl.run) begin
                q <= wdata;
            end
        end

        assign rate[gb*DATA_W +: DATA_W] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (wr_ctl) begin
                ctl.run    <= wdata[BIT_RUN];
                ctl.src    <= src_e'(wdata[BIT_SRC]);
                ctl.irq_en <= wdata[BIT_IE];
            end
            if (timeout) begin
                ctl.flag <= 1'b1;
            end else if (wr_ctl && wdata[BIT_FLAG]) begin
                ctl.flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata = ctl_to_byte(ctl);
        end else if (int'(addr) < RATE_BYTES) begin
            rdata = rate[(RATE_BYTES - 1 - int'(addr))*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/wtt_tick_gen.sv
module wtt_tick_gen
    import wtt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic slow_clk,
    input  logic run,
    input  src_e src,
    output logic tick
);

    logic                   slow_on;
    logic [SYNC_STAGES:0]   sync_q;
    logic [GATE_W-1:0]      gate_cnt;
    logic                   slow_rise;
    logic                   gate_open;

    assign slow_on = run && (src == SRC_SLOW);

    // The synchronizer is held cleared while the slow path is idle (gated off).
    always_ff @(posedge clk) begin
        if (rst || !slow_on) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], slow_clk};
        end
    end

    assign slow_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];
    assign gate_open = (gate_cnt == GATE_W'(GATE_EDGES));

    // Gate release: the first GATE_EDGES synchronized edges after start are dropped.
    always_ff @(posedge clk) begin
        if (rst || !slow_on) begin
            gate_cnt <= '0;
        end else if (slow_rise && !gate_open) begin
            gate_cnt <= gate_cnt + GATE_W'(1);
        end
    end

    always_comb begin
        if (!run) begin
            tick = 1'b0;
        end else if (src == SRC_BUS) begin
            tick = 1'b1;
        end else begin
            tick = slow_rise && gate_open;
        end
    end

endmodule

// File: rtl/wtt_counter.sv
module wtt_counter
    import wtt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  count,
    output logic              timeout
);

    logic [CNT_W-1:0] limit;

    assign limit   = terminal_count(rate);
    assign timeout = tick && (count == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (tick) begin
            count <= timeout ? '0 : count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wake_tick_timer.sv
module wake_tick_timer
    import wtt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [RATE_W-1:0] rate;
    ctl_t              ctl;
    logic              tick;
    logic              timeout;
    logic [CNT_W-1:0]  count;
    logic              run_en;
    logic              irq_en;
    logic              flag;

    wtt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .timeout (timeout),
        .rdata   (reg_rdata),
        .rate    (rate),
        .ctl     (ctl)
    );

    wtt_tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .slow_clk (slow_clk),
        .run      (ctl.run),
        .src      (ctl.src),
        .tick     (tick)
    );

    wtt_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.run),
        .tick    (tick),
        .rate    (rate),
        .count   (count),
        .timeout (timeout)
    );

    assign run_en = ctl.run;
    assign irq_en = ctl.irq_en;
    assign flag   = ctl.flag;
    assign irq    = flag && irq_en;

endmodule

// File: rtl/wtt_checker.sv
module wtt_checker
    import wtt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              en,
    input logic              ie,
    input logic              flag,
    input logic              timeout,
    input logic [RATE_W-1:0] rate,
    input logic [CNT_W-1:0]  count
);

    assert_rate_locked_R3: assert property (@(posedge clk) disable iff (rst)
        $past(en) |-> $stable(rate));

    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (count == '0));

    assert_timeout_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
        timeout |=> flag);

    assert_timeout_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
        timeout |-> en);

    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        en |-> (count <= terminal_count(rate)));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr && (addr == ADDR_CTRL) && wdata[BIT_FLAG])) |=> flag);

    assert_flag_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(timeout));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && ie));

endmodule

bind wake_tick_timer wtt_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .irq     (irq),
    .en      (run_en),
    .ie      (irq_en),
    .flag    (flag),
    .timeout (timeout),
    .rate    (rate),
    .count   (count)
);

// File: tb/wake_tick_timer_test.sv
module wake_tick_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_clk = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Slow clock: period of 8 bus cycles, changed on the falling bus edge.
    int slow_phase = 0;
    always @(negedge clk) begin
        slow_phase = (slow_phase + 1) % 8;
        slow_clk  <= (slow_phase < 4);
    end

    wake_tick_timer uut (
        .clk       (clk),
        .rst       (rst),
        .slow_clk  (slow_clk),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // {addr, write data, expected read-back of the same address}
    localparam int NVEC = 8;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd1, 8'h34, 8'h34},   // R2 low byte
        {2'd0, 8'h12, 8'h12},   // R2 high byte
        {2'd2, 8'h05, 8'h05},   // R9 run + irq enable, slow base
        {2'd1, 8'hFF, 8'h34},   // R3 locked while running
        {2'd0, 8'h00, 8'h12},   // R3 locked while running
        {2'd2, 8'h78, 8'h00},   // R9 unused bits read 0, run cleared
        {2'd1, 8'h56, 8'h56},   // R2 writable again once stopped
        {2'd3, 8'hAA, 8'h00}    // R9 unused address
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_flag(input int max, output int n);
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!irq && n < max);
    endtask

    task automatic stop_all();
        reg_write(2'd2, 8'h00);
        reg_write(2'd2, 8'h80);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R4 actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n;

        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        reg_read(2'd0, d); check("R1 rate high", d, 8'h00);
        reg_read(2'd1, d); check("R1 rate low", d, 8'h00);
        reg_read(2'd2, d); check("R1 control", d, 8'h00);
        check("R1 irq", irq, 0);

        // Register vector walk: R2 R3 R9
        for (int i = 0; i < NVEC; i++) begin
            reg_write(VEC[i][17:16], VEC[i][15:8]);
            reg_read(VEC[i][17:16], d);
            check($sformatf("R2/R3/R9 vector %0d", i), d, VEC[i][7:0]);
        end
        reg_read(2'd0, d); check("R3 high byte kept", d, 8'h12);

        // R4 bus base, rate 3 -> 8 cycles
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h03);
        reg_write(2'd2, 8'h07);
        wait_flag(100, n);
        check("R4 first bus interval", n, 8);
        reg_write(2'd2, 8'h87);              // clear one cycle after timeout
        wait_flag(100, n);
        check("R4 repeat interval", n, 7);

        // R10 missed periods: leave flag set across two timeouts
        repeat (16) @(posedge clk);
        #1;
        reg_write(2'd2, 8'h87);
        wait_flag(100, n);
        check("R10 no drift while flag pending", n, 7);

        // R8 irq gating and R7 write-0 no effect
        reg_write(2'd2, 8'h03);
        check("R8 irq low with enable clear", irq, 0);
        reg_read(2'd2, d);
        check("R7 write 0 keeps flag", d[7], 1);
        reg_write(2'd2, 8'h07);
        check("R8 irq high with flag and enable", irq, 1);

        // R6 stop stops counting
        stop_all();
        reg_read(2'd2, d); check("R7 clear by writing 1", d, 8'h00);
        repeat (30) @(posedge clk);
        #1;
        reg_read(2'd2, d); check("R6 stopped timer never times out", d[7], 0);

        // R6 restart gives a full new interval
        reg_write(2'd2, 8'h07);
        repeat (5) @(posedge clk);
        #1;
        reg_write(2'd2, 8'h06);
        reg_write(2'd2, 8'h07);
        wait_flag(100, n);
        check("R6 fresh interval after restart", n, 8);
        stop_all();

        // R7 set beats clear in the same cycle, rate 0 -> 2 cycles
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, 8'h03);              // edge E
        reg_write(2'd3, 8'h00);              // edge E+1
        reg_write(2'd2, 8'h83);              // edge E+2 coincides with timeout
        check("R7 timeout beats clear", reg_rdata[7], 1);
        reg_write(2'd2, 8'h83);              // edge E+3, no timeout
        check("R7 clear takes effect", reg_rdata[7], 0);
        stop_all();

        // R5 slow base, rate 1 -> 4 slow edges = 32 bus cycles
        reg_write(2'd1, 8'h01);
        reg_write(2'd2, 8'h05);
        wait_flag(200, n);
        check_range("R5 first slow interval with gate latency", n, 48, 61);
        reg_write(2'd2, 8'h85);
        wait_flag(200, n);
        check("R5 steady slow interval", n, 31);
        stop_all();

        // R4 largest rate 0xFFFF -> 131072 cycles
        reg_write(2'd0, 8'hFF);
        reg_write(2'd1, 8'hFF);
        reg_write(2'd2, 8'h07);
        wait_flag(140000, n);
        check("R4 full-width interval", n, 131072);
        stop_all();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule